// File: doc/BRIEF.md
# Message Object Transfer Interface

This block sits between a CPU register port and a store of 32 message objects. Software never addresses the object store itself. It loads a set of staging registers: an arbitration pair, a control word, two 4-byte payload groups (A holds bytes 0 to 3, B holds bytes 4 to 7) and a transfer mask. It then writes an object number to the command register. A small state machine then runs a fixed-length read-modify-write or fetch between the staging set and the chosen object.

The transfer mask picks the direction and the fields that move. A transmit request can be forced to 1 by a mask bit, or copied from the staged control word. The per-object transmit-request, new-data, interrupt-pending and valid flags are exposed as read-only 32-bit bitmaps. Each bitmap is split over two 16-bit registers. A pin selects a little- or big-endian view of the payload registers.

The state machine has three states. IDLE waits. FETCH reads the target object into a holding register. APPLY either writes the merged object back or loads the staging set. The transitions are: IDLE→FETCH on an accepted command write, FETCH→APPLY always, and APPLY→IDLE always.

Top module: `mif_xfer`

## Requirements
- R1: After reset, every staging register, the command register and all eight bitmap registers read 0, and `busy` is 0.
- R2: With `big_endian`=0, payload address 5 holds {byte1,byte0}, address 6 holds {byte3,byte2}, address 7 holds {byte5,byte4} and address 8 holds {byte7,byte6}. In each pair the high byte is in bits 15:8.
- R3: With `big_endian`=1, address 5 holds {byte2,byte3}, address 6 holds {byte0,byte1}, address 7 holds {byte6,byte7} and address 8 holds {byte4,byte5}. Writes and reads use the same mapping.
- R4: A write of object number n (1..32) to address 0 while idle raises `busy` for exactly the two following cycles. The result is visible once `busy` falls. Object n is bit n-1 of the low bitmap register (n ≤ 16) or bit n-17 of the high register. Address 0 reads {busy at bit 15, last accepted object number in bits 5:0}.
- R5: A command write with object number 0 or above 32 is ignored. `busy` stays 0 and address 0 keeps its value.
- R6: While `busy` is 1, writes to any register, including the command register, are ignored.
- R7: In a write transfer (mask bit 7 = 1), only the fields enabled in the mask are copied into the object. Bit 5 enables arbitration, bit 4 control, bit 1 group A and bit 0 group B. Each group moves as a whole 4-byte unit, and disabled fields keep their old contents.
- R8: In a read transfer (mask bit 7 = 0), only the enabled fields are loaded into staging. The control word read back carries the object's new-data flag (bit 15), interrupt-pending flag (bit 13) and transmit-request flag (bit 8).
- R9: A write transfer with mask bit 2 = 1 sets the object's transmit request to 1, whatever the staged control word holds.
- R10: A write transfer with mask bit 2 = 0 and control enabled loads the object's transmit request, new-data and interrupt-pending flags from staged control bits 8, 15 and 13. With control disabled, these flags are unchanged.
- R11: A write transfer with arbitration enabled loads the object's valid flag from bit 15 of the arbitration-high register (address 3). Address 2 holds the low arbitration half.
- R12: Bitmap registers are read-only. Addresses 9/10 hold the transmit requests, 11/12 new data, 13/14 interrupt pending and 15/16 valid, low register first. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian | input | 1 | Selects the big-endian payload view |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions assume that software does not change `big_endian` or poll for results while a transfer runs. They also assume that the object store is only read in fields that were written first, because object contents are not reset. The stimulus writes every field of an object before any transfer reads that field back. It holds `big_endian` steady through each transfer and waits for `busy` to fall before sampling results. The writes attempted during `busy` are deliberate and are expected to have no effect.

// File: rtl/mif_pkg.sv
package mif_pkg;
    localparam int OBJ_CNT = 32;
    localparam int IDX_W   = $clog2(OBJ_CNT);
    localparam int NUM_W   = IDX_W + 1;
    localparam int REG_W   = 16;
    localparam int ADDR_W  = 5;
    localparam int GRP_W   = 2 * REG_W;

    localparam logic [ADDR_W-1:0] A_CMD    = 5'd0;
    localparam logic [ADDR_W-1:0] A_MASK   = 5'd1;
    localparam logic [ADDR_W-1:0] A_ARB_LO = 5'd2;
    localparam logic [ADDR_W-1:0] A_ARB_HI = 5'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'd4;
    localparam logic [ADDR_W-1:0] A_DAT0   = 5'd5;
    localparam logic [ADDR_W-1:0] A_DAT3   = 5'd8;
    localparam logic [ADDR_W-1:0] A_TX_LO  = 5'd9;
    localparam logic [ADDR_W-1:0] A_TX_HI  = 5'd10;
    localparam logic [ADDR_W-1:0] A_ND_LO  = 5'd11;
    localparam logic [ADDR_W-1:0] A_ND_HI  = 5'd12;
    localparam logic [ADDR_W-1:0] A_IP_LO  = 5'd13;
    localparam logic [ADDR_W-1:0] A_IP_HI  = 5'd14;
    localparam logic [ADDR_W-1:0] A_MV_LO  = 5'd15;
    localparam logic [ADDR_W-1:0] A_MV_HI  = 5'd16;

    localparam int CB_NEWDAT = 15;
    localparam int CB_INTPND = 13;
    localparam int CB_TXRQ   = 8;
    localparam int AB_VALID  = GRP_W - 1;
    localparam logic [REG_W-1:0] CTRL_FLAG_BITS = 16'hA100;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_APPLY = 2'd2
    } xfer_state_t;

    typedef struct packed {
        logic wr;
        logic arb;
        logic ctrl;
        logic txset;
        logic grp_a;
        logic grp_b;
    } xmask_t;

    typedef struct packed {
        logic [GRP_W-1:0] arb;
        logic [REG_W-1:0] ctrl;
        logic [GRP_W-1:0] grp_a;
        logic [GRP_W-1:0] grp_b;
    } mobj_t;

    function automatic xmask_t mask_decode(input logic [REG_W-1:0] raw);
        xmask_t m;
        m.wr    = raw[7];
        m.arb   = raw[5];
        m.ctrl  = raw[4];
        m.txset = raw[2];
        m.grp_a = raw[1];
        m.grp_b = raw[0];
        return m;
    endfunction

    function automatic logic [REG_W-1:0] mask_encode(input xmask_t m);
        logic [REG_W-1:0] r;
        r    = '0;
        r[7] = m.wr;
        r[5] = m.arb;
        r[4] = m.ctrl;
        r[2] = m.txset;
        r[1] = m.grp_a;
        r[0] = m.grp_b;
        return r;
    endfunction
endpackage

// File: rtl/mif_ctrl.sv
module mif_ctrl
    import mif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [NUM_W-1:0] cmd_obj,
    output logic             busy,
    output logic             fetch_en,
    output logic             apply_en,
    output logic [IDX_W-1:0] obj_idx,
    output logic [NUM_W-1:0] last_obj
);
    localparam logic [NUM_W-1:0] OBJ_MAX = NUM_W'(OBJ_CNT);

    xfer_state_t state_q, state_d;
    logic        obj_ok;
    logic        accept;

    assign obj_ok = (cmd_obj != '0) && (cmd_obj <= OBJ_MAX);
    assign accept = cmd_wr && obj_ok && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_APPLY;
            ST_APPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obj_idx  <= '0;
            last_obj <= '0;
        end else if (accept) begin
            obj_idx  <= IDX_W'(cmd_obj - NUM_W'(1));
            last_obj <= cmd_obj;
        end
    end

    always_comb begin
        busy     = 1'b0;
        fetch_en = 1'b0;
        apply_en = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: begin busy = 1'b1; fetch_en = 1'b1; end
            ST_APPLY: begin busy = 1'b1; apply_en = 1'b1; end
            default:  ;
        endcase
    end

    AST_FETCH_TO_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_APPLY)); // R4
    AST_APPLY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY) |=> !busy); // R4
    AST_BAD_OBJ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr && !obj_ok) |=> !busy); // R5
endmodule

// File: rtl/mif_store.sv
module mif_store
    import mif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_en,
    input  logic               apply_en,
    input  logic [IDX_W-1:0]   obj_idx,
    input  xmask_t             mask,
    input  mobj_t              stage,
    output mobj_t              rd_obj,
    output logic [OBJ_CNT-1:0] txrq_vec,
    output logic [OBJ_CNT-1:0] newdat_vec,
    output logic [OBJ_CNT-1:0] intpnd_vec,
    output logic [OBJ_CNT-1:0] valid_vec
);
    mobj_t mem [OBJ_CNT];
    mobj_t fetch_view;
    mobj_t merged;
    logic  do_write;
    logic  tx_next, nd_next, ip_next, mv_next;

    assign do_write = apply_en && mask.wr;

    always_comb begin
        fetch_view = mem[obj_idx];
        fetch_view.ctrl = (mem[obj_idx].ctrl & ~CTRL_FLAG_BITS);
        fetch_view.ctrl[CB_NEWDAT] = newdat_vec[obj_idx];
        fetch_view.ctrl[CB_INTPND] = intpnd_vec[obj_idx];
        fetch_view.ctrl[CB_TXRQ]   = txrq_vec[obj_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rd_obj <= '0;
        else if (fetch_en) rd_obj <= fetch_view;
    end

    always_comb begin
        merged.arb   = mask.arb   ? stage.arb   : rd_obj.arb;
        merged.ctrl  = (mask.ctrl ? stage.ctrl : rd_obj.ctrl) & ~CTRL_FLAG_BITS;
        merged.grp_a = mask.grp_a ? stage.grp_a : rd_obj.grp_a;
        merged.grp_b = mask.grp_b ? stage.grp_b : rd_obj.grp_b;
        if (mask.txset)     tx_next = 1'b1;
        else if (mask.ctrl) tx_next = stage.ctrl[CB_TXRQ];
        else                tx_next = rd_obj.ctrl[CB_TXRQ];
        nd_next = mask.ctrl ? stage.ctrl[CB_NEWDAT] : rd_obj.ctrl[CB_NEWDAT];
        ip_next = mask.ctrl ? stage.ctrl[CB_INTPND] : rd_obj.ctrl[CB_INTPND];
        mv_next = mask.arb  ? stage.arb[AB_VALID]   : valid_vec[obj_idx];
    end

    always_ff @(posedge clk) begin
        if (do_write) mem[obj_idx] <= merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txrq_vec   <= '0;
            newdat_vec <= '0;
            intpnd_vec <= '0;
            valid_vec  <= '0;
        end else if (do_write) begin
            txrq_vec[obj_idx]   <= tx_next;
            newdat_vec[obj_idx] <= nd_next;
            intpnd_vec[obj_idx] <= ip_next;
            valid_vec[obj_idx]  <= mv_next;
        end
    end

    AST_TXSET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (do_write && mask.txset) |=> txrq_vec[$past(obj_idx)]); // R9
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !do_write |=> ($stable(txrq_vec) && $stable(newdat_vec) && $stable(intpnd_vec) && $stable(valid_vec))); // R10
    AST_ONE_OBJECT: assert property (@(posedge clk) disable iff (!rst_n)
        do_write |=> ($countones(txrq_vec ^ $past(txrq_vec)) <= 1)); // R4
endmodule

// File: rtl/mif_regs.sv
module mif_regs
    import mif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               big_endian,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               busy,
    input  logic               load_stage,
    input  mobj_t              rd_obj,
    input  logic [NUM_W-1:0]   last_obj,
    input  logic [OBJ_CNT-1:0] txrq_vec,
    input  logic [OBJ_CNT-1:0] newdat_vec,
    input  logic [OBJ_CNT-1:0] intpnd_vec,
    input  logic [OBJ_CNT-1:0] valid_vec,
    output xmask_t             mask,
    output mobj_t              stage
);
    xmask_t           mask_q;
    mobj_t            stage_q;
    logic             wr_ok;
    logic             is_data;
    logic [1:0]       dsel;
    logic             phys_word;
    logic [REG_W-1:0] lane_in;
    logic [GRP_W-1:0] grp_sel;
    logic [REG_W-1:0] word_sel;

    assign wr_ok     = reg_wr && !busy;
    assign is_data   = (reg_addr >= A_DAT0) && (reg_addr <= A_DAT3);
    assign dsel      = 2'(reg_addr - A_DAT0);
    assign phys_word = dsel[0] ^ big_endian;
    assign lane_in   = big_endian ? {reg_wdata[7:0], reg_wdata[15:8]} : reg_wdata;
    assign mask      = mask_q;
    assign stage     = stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            stage_q <= '0;
        end else if (load_stage) begin
            if (mask_q.arb)   stage_q.arb   <= rd_obj.arb;
            if (mask_q.ctrl)  stage_q.ctrl  <= rd_obj.ctrl;
            if (mask_q.grp_a) stage_q.grp_a <= rd_obj.grp_a;
            if (mask_q.grp_b) stage_q.grp_b <= rd_obj.grp_b;
        end else if (wr_ok) begin
            if (reg_addr == A_MASK)   mask_q <= mask_decode(reg_wdata);
            if (reg_addr == A_ARB_LO) stage_q.arb[REG_W-1:0] <= reg_wdata;
            if (reg_addr == A_ARB_HI) stage_q.arb[GRP_W-1:REG_W] <= reg_wdata;
            if (reg_addr == A_CTRL)   stage_q.ctrl <= reg_wdata;
            if (is_data) begin
                if (!dsel[1]) stage_q.grp_a[REG_W*phys_word +: REG_W] <= lane_in;
                else          stage_q.grp_b[REG_W*phys_word +: REG_W] <= lane_in;
            end
        end
    end

    always_comb begin
        grp_sel  = dsel[1] ? stage_q.grp_b : stage_q.grp_a;
        word_sel = grp_sel[REG_W*phys_word +: REG_W];
        if (big_endian) word_sel = {word_sel[7:0], word_sel[15:8]};
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CMD:    reg_rdata = {busy, {(REG_W-1-NUM_W){1'b0}}, last_obj};
            A_MASK:   reg_rdata = mask_encode(mask_q);
            A_ARB_LO: reg_rdata = stage_q.arb[REG_W-1:0];
            A_ARB_HI: reg_rdata = stage_q.arb[GRP_W-1:REG_W];
            A_CTRL:   reg_rdata = stage_q.ctrl;
            A_TX_LO:  reg_rdata = txrq_vec[REG_W-1:0];
            A_TX_HI:  reg_rdata = txrq_vec[OBJ_CNT-1:REG_W];
            A_ND_LO:  reg_rdata = newdat_vec[REG_W-1:0];
            A_ND_HI:  reg_rdata = newdat_vec[OBJ_CNT-1:REG_W];
            A_IP_LO:  reg_rdata = intpnd_vec[REG_W-1:0];
            A_IP_HI:  reg_rdata = intpnd_vec[OBJ_CNT-1:REG_W];
            A_MV_LO:  reg_rdata = valid_vec[REG_W-1:0];
            A_MV_HI:  reg_rdata = valid_vec[OBJ_CNT-1:REG_W];
            default:  reg_rdata = is_data ? word_sel : '0;
        endcase
    end

    AST_MASK_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mask_q)); // R6
    AST_STAGE_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load_stage) |=> $stable(stage_q)); // R6
endmodule

// File: rtl/mif_xfer.sv
module mif_xfer
    import mif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              busy
);
    logic               fetch_en, apply_en;
    logic [IDX_W-1:0]   obj_idx;
    logic [NUM_W-1:0]   last_obj;
    xmask_t             mask;
    mobj_t              stage, rd_obj;
    logic [OBJ_CNT-1:0] txrq_vec, newdat_vec, intpnd_vec, valid_vec;
    logic               cmd_wr;
    logic               load_stage;

    assign cmd_wr     = reg_wr && (reg_addr == A_CMD);
    assign load_stage = apply_en && !mask.wr;

    mif_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_obj  (reg_wdata[NUM_W-1:0]),
        .busy     (busy),
        .fetch_en (fetch_en),
        .apply_en (apply_en),
        .obj_idx  (obj_idx),
        .last_obj (last_obj)
    );

    mif_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_en   (fetch_en),
        .apply_en   (apply_en),
        .obj_idx    (obj_idx),
        .mask       (mask),
        .stage      (stage),
        .rd_obj     (rd_obj),
        .txrq_vec   (txrq_vec),
        .newdat_vec (newdat_vec),
        .intpnd_vec (intpnd_vec),
        .valid_vec  (valid_vec)
    );

    mif_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .big_endian (big_endian),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .load_stage (load_stage),
        .rd_obj     (rd_obj),
        .last_obj   (last_obj),
        .txrq_vec   (txrq_vec),
        .newdat_vec (newdat_vec),
        .intpnd_vec (intpnd_vec),
        .valid_vec  (valid_vec),
        .mask       (mask),
        .stage      (stage)
    );
endmodule

// File: tb/mif_xfer_test.sv
`timescale 1ns/1ps
module mif_xfer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        busy;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    mif_xfer uut (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
    );

    localparam logic [15:0] MK_WR = 16'h0080, MK_ARB = 16'h0020, MK_CTL = 16'h0010;
    localparam logic [15:0] MK_TX = 16'h0004, MK_DA = 16'h0002, MK_DB = 16'h0001;

    // behavioural reference model
    bit [7:0]  ob_byte [32][8];
    bit [31:0] ob_arb [32];
    bit [15:0] ob_ctl [32];
    bit [31:0] f_tx, f_nd, f_ip, f_mv;
    bit [7:0]  s_byte [8];
    bit [31:0] s_arb;
    bit [15:0] s_ctl, s_mask;
    int        s_last, pend, tgt;

    function automatic int hi_idx(int k, bit be);
        return be ? 2 * (k ^ 1) : 2 * k + 1;
    endfunction
    function automatic int lo_idx(int k, bit be);
        return be ? 2 * (k ^ 1) + 1 : 2 * k;
    endfunction

    task automatic do_transfer();
        int o = tgt;
        if (s_mask[7]) begin
            if (s_mask[5]) begin ob_arb[o] = s_arb; f_mv[o] = s_arb[31]; end
            if (s_mask[4]) begin
                ob_ctl[o] = s_ctl & 16'h5EFF;
                f_nd[o] = s_ctl[15];
                f_ip[o] = s_ctl[13];
            end
            if (s_mask[2]) f_tx[o] = 1'b1;
            else if (s_mask[4]) f_tx[o] = s_ctl[8];
            for (int b = 0; b < 8; b++)
                if ((b < 4 && s_mask[1]) || (b >= 4 && s_mask[0])) ob_byte[o][b] = s_byte[b];
        end else begin
            if (s_mask[5]) s_arb = ob_arb[o];
            if (s_mask[4]) begin
                s_ctl = ob_ctl[o];
                s_ctl[15] = f_nd[o];
                s_ctl[13] = f_ip[o];
                s_ctl[8]  = f_tx[o];
            end
            for (int b = 0; b < 8; b++)
                if ((b < 4 && s_mask[1]) || (b >= 4 && s_mask[0])) s_byte[b] = ob_byte[o][b];
        end
    endtask

    always @(posedge clk) begin
        bit was_busy;
        cyc++;
        if (!rst_n) begin
            f_tx = 0; f_nd = 0; f_ip = 0; f_mv = 0;
            s_arb = 0; s_ctl = 0; s_mask = 0; s_last = 0; pend = 0;
            for (int b = 0; b < 8; b++) s_byte[b] = 0;
        end else begin
            was_busy = (pend > 0);
            if (was_busy) begin
                pend--;
                if (pend == 0) do_transfer();
            end
            if (!was_busy && reg_wr) begin
                case (reg_addr)
                    5'd0: if (reg_wdata[5:0] >= 1 && reg_wdata[5:0] <= 32) begin
                              s_last = reg_wdata[5:0]; tgt = s_last - 1; pend = 2;
                          end
                    5'd1: s_mask = reg_wdata & 16'h00B7;
                    5'd2: s_arb[15:0] = reg_wdata;
                    5'd3: s_arb[31:16] = reg_wdata;
                    5'd4: s_ctl = reg_wdata;
                    5'd5, 5'd6, 5'd7, 5'd8: begin
                        s_byte[hi_idx(int'(reg_addr) - 5, big_endian)] = reg_wdata[15:8];
                        s_byte[lo_idx(int'(reg_addr) - 5, big_endian)] = reg_wdata[7:0];
                    end
                    default: ;
                endcase
            end
        end
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // busy compared against the model every clock (R4)
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (busy !== (pend > 0)) begin
                failures++;
                $display("FAIL R4 busy got=%b exp=%b", busy, pend > 0);
            end
        end
    end

    function automatic bit [15:0] expect_rd(int a);
        case (a)
            0: return {pend > 0, 9'b0, 6'(s_last)};
            1: return s_mask;
            2: return s_arb[15:0];
            3: return s_arb[31:16];
            4: return s_ctl;
            5, 6, 7, 8: return {s_byte[hi_idx(a - 5, big_endian)], s_byte[lo_idx(a - 5, big_endian)]};
            9:  return f_tx[15:0];
            10: return f_tx[31:16];
            11: return f_nd[15:0];
            12: return f_nd[31:16];
            13: return f_ip[15:0];
            14: return f_ip[31:16];
            15: return f_mv[15:0];
            16: return f_mv[31:16];
            default: return 16'h0;
        endcase
    endfunction

    task automatic sweep(string tag);
        for (int a = 0; a <= 16; a++) begin
            bit [15:0] e;
            reg_addr = 5'(a);
            #0.4;
            e = expect_rd(a);
            checks++;
            if (reg_rdata !== e) begin
                failures++;
                $display("FAIL %s addr=%0d got=%h exp=%h", tag, a, reg_rdata, e);
            end
        end
    endtask

    task automatic wr(int a, bit [15:0] d);
        reg_addr = 5'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic stage_all(bit [15:0] alo, bit [15:0] ahi, bit [15:0] c, bit [15:0] d0,
                             bit [15:0] d1, bit [15:0] d2, bit [15:0] d3);
        wr(2, alo); wr(3, ahi); wr(4, c);
        wr(5, d0); wr(6, d1); wr(7, d2); wr(8, d3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sweep("R1");

        // R2: little-endian lanes
        stage_all(16'h0000, 16'h0000, 16'h0000, 16'h1100, 16'h3322, 16'h5544, 16'h7766);
        sweep("R2");
        // R3: big-endian view of the same bytes, then write in big-endian view
        big_endian = 1'b1;
        sweep("R3");
        wr(5, 16'hA1B2); wr(8, 16'hC3D4);
        sweep("R3");
        big_endian = 1'b0;
        sweep("R3");

        // R7/R10/R11: full write to object 5
        stage_all(16'h1234, 16'h8ABC, 16'h8003, 16'h0201, 16'h0403, 16'h0605, 16'h0807);
        wr(1, MK_WR | MK_ARB | MK_CTL | MK_DA | MK_DB);
        wr(0, 16'd5);
        // R6: writes during busy are ignored
        wr(5, 16'hFFFF);
        wr(0, 16'd9);
        settle();
        sweep("R6");

        // R9: txset to object 20 with staged txrq 0
        stage_all(16'h5555, 16'h8001, 16'h0000, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD);
        wr(1, MK_WR | MK_ARB | MK_TX | MK_DA | MK_DB);
        wr(0, 16'd20);
        settle();
        sweep("R9");

        // R10: control-only write clears txrq of object 20, sets intpnd
        wr(4, 16'h2005);
        wr(1, MK_WR | MK_CTL);
        wr(0, 16'd20);
        settle();
        sweep("R10");

        // R8: partial read of object 5 (no group B)
        stage_all(16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'hEEEE, 16'hEEEE);
        wr(1, MK_ARB | MK_CTL | MK_DA);
        wr(0, 16'd5);
        settle();
        sweep("R8");

        // R7: data-A-only write to object 5, then full read back
        wr(5, 16'h9911); wr(6, 16'h9922);
        wr(1, MK_WR | MK_DA);
        wr(0, 16'd5);
        settle();
        stage_all(16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
        wr(1, MK_ARB | MK_CTL | MK_DA | MK_DB);
        wr(0, 16'd5);
        settle();
        sweep("R7");
        // full read of object 20: arbitration preserved by control-only write
        wr(0, 16'd20);
        settle();
        sweep("R7");

        // R5: invalid object numbers
        wr(0, 16'd0);
        @(negedge clk);
        sweep("R5");
        wr(0, 16'd33);
        @(negedge clk);
        sweep("R5");

        // R12: bitmap registers are read-only
        for (int a = 9; a <= 16; a++) wr(a, 16'hFFFF);
        sweep("R12");

        // R4/R11: boundary objects 1 and 32
        stage_all(16'h0001, 16'h8000, 16'hA000, 16'h1, 16'h2, 16'h3, 16'h4);
        wr(1, MK_WR | MK_ARB | MK_CTL | MK_TX | MK_DA | MK_DB);
        wr(0, 16'd1);
        settle();
        wr(0, 16'd32);
        settle();
        sweep("R11");
        // R10: write with control disabled and no txset leaves flags
        wr(1, MK_WR | MK_DA);
        wr(0, 16'd32);
        settle();
        sweep("R10");
        // R11: clear valid on object 32 via arbitration
        wr(3, 16'h0000);
        wr(1, MK_WR | MK_ARB);
        wr(0, 16'd32);
        settle();
        sweep("R11");
        // R4: busy flag visible in the command register mid-transfer
        wr(0, 16'd1);
        sweep("R4");
        settle();
        sweep("R4");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule